// File: doc/BRIEF.md
# Block Address Sequence Generator

This block produces a stream of memory addresses for algorithms that work through a large data set in blocks: transforms, filters, matrix kernels and image pan or zoom. Each block is a run of addresses spaced by a fixed address step. After the last address of a block, the block base moves by a separate block step and the next run begins. This repeats for a programmed number of blocks. One start pulse runs the whole sequence, and one address comes out on every cycle.

The generator works either as a single 24-bit sequencer or as two independent 12-bit sequencers. In the split case, lane 0 can serve reads and lane 1 writes, for example. Each lane has its own valid, block-end, sequence-end, busy and start-echo flags. The start echo lets several generators run in step. Configuration is loaded through a narrow write-only port. A select line chooses between loading a register pointer and loading a 7-bit slice of the pointed register. A running sequence uses a snapshot of the registers taken at its start.

Top module: `addr_seq_gen`

## Requirements
- R1: After reset every output is low, including `addr_out`, and both lanes are idle.
- R2: A start sampled on a rising edge puts the first address out after that edge. Addresses then follow on consecutive cycles. Address k of block b equals base + b*block_step + k*addr_step, modulo 2^24 in joined mode and modulo 2^12 per lane in split mode.
- R3: `busy` and `addr_valid` of a lane are high on exactly the cycles that carry a generated address. With no address, `busy`, `blk_done`, `seq_done` and `start_out` of that lane are low.
- R4: Register 2 holds the number of addresses per block minus one. `blk_done` is high on the last address of every block, including on every address when the field is zero.
- R5: Register 4 holds the number of blocks minus one. `seq_done` is high only on the last address of the final block, and the lane is idle on the following cycle.
- R6: `start_out` of a lane is a one-cycle pulse on the cycle that carries the first address of a sequence.
- R7: A start that arrives while the lane is busy is ignored, and the running sequence is unchanged.
- R8: Register writes made while a sequence runs do not affect it. They apply to the next start.
- R9: A write needs `cpu_cs` and `cpu_wr` both high. With `cpu_a0` low, data bits [2:0] select register 0 base, 1 address step, 2 block length, 3 block step, 4 block count or 5 mode, and bits [4:3] select a 7-bit slice. With `cpu_a0` high, the data loads register bits slice*7 upward, truncated at bit 23. A write without both strobes changes nothing.
- R10: When mode register bit 0 is set, lane 0 uses bits [11:0] of every register and drives `addr_out[11:0]`. Lane 1 uses bits [23:12], starts from `start_in[1]` and drives `addr_out[23:12]`. Each lane runs on its own.
- R11: In joined mode, `start_in[1]` is ignored and every lane 1 flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_cs | input | 1 | Configuration port select |
| cpu_wr | input | 1 | Configuration write strobe |
| cpu_a0 | input | 1 | Low: pointer write; high: data slice write |
| cpu_d | input | 7 | Configuration data |
| start_in | input | 2 | Start request per lane (bit 1 used only in split mode) |
| addr_out | output | 24 | Generated address (halves per lane in split mode) |
| addr_valid | output | 2 | Address present, per lane |
| blk_done | output | 2 | Last address of a block, per lane |
| seq_done | output | 2 | Last address of the sequence, per lane |
| busy | output | 2 | Sequence in progress, per lane |
| start_out | output | 2 | Start echo on the first address, per lane |

## Verification
The hardest case to reach is two split lanes running with different geometries, overlapped in time. Each lane's flags must stay tied to its own half of the address bus while the other lane changes. The stimulus programs distinct upper and lower halves into every register and starts lane 1 a few cycles after lane 0. A separate expectation queue for each lane then checks that the two streams interleave freely. Two further cases are timed against a long running sequence: a mid-sequence restart attempt, and a register rewrite issued while busy, which must show up only in the following run.

// File: rtl/addr_seq_pkg.sv
package addr_seq_pkg;
  localparam int NREG     = 6;
  localparam int REG_BASE = 0;
  localparam int REG_AINC = 1;
  localparam int REG_LEN  = 2;
  localparam int REG_BINC = 3;
  localparam int REG_NBLK = 4;
  localparam int REG_MODE = 5;
endpackage

// File: rtl/addr_seq_cfg.sv
module addr_seq_cfg
  import addr_seq_pkg::*;
#(
  parameter int DW = 7,
  parameter int RW = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cs,
  input  logic                     wr,
  input  logic                     a0,
  input  logic [DW-1:0]            d,
  output logic [NREG-1:0][RW-1:0]  regs
);
  localparam int NCH = (RW + DW - 1) / DW;
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int IW  = $clog2(NREG);

  logic [IW-1:0]       sel_q;
  logic [CHW-1:0]      ch_q;
  logic [NCH*DW-1:0]   wide;
  logic                sel_ok;

  assign sel_ok = (sel_q < IW'(NREG));

  always_comb begin
    wide = '0;
    if (sel_ok) wide[RW-1:0] = regs[sel_q];
    wide[ch_q*DW +: DW] = d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      ch_q  <= '0;
      regs  <= '0;
    end else if (cs && wr) begin
      if (!a0) begin
        sel_q <= d[IW-1:0];
        ch_q  <= d[IW +: CHW];
      end else if (sel_ok) begin
        regs[sel_q] <= wide[RW-1:0];
      end
    end
  end

  // R9: registers move only on a qualified write
  a_r9_no_write_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !(cs && wr) |=> $stable(regs));
  // R9: a pointer write leaves the register contents alone
  a_r9_pointer_write_keeps_regs: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && !a0) |=> $stable(regs));
endmodule

// File: rtl/addr_seq_lane.sv
module addr_seq_lane #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] cfg_base,
  input  logic [W-1:0] cfg_ainc,
  input  logic [W-1:0] cfg_len,
  input  logic [W-1:0] cfg_binc,
  input  logic [W-1:0] cfg_nblk,
  output logic [W-1:0] addr,
  output logic         valid,
  output logic         bdone,
  output logic         done,
  output logic         sout
);
  logic [W-1:0] c_ainc, c_len, c_binc, c_nblk;
  logic [W-1:0] bbase, off, pos, blk;
  logic [W-1:0] pos_n, blk_n, off_n, bbase_n;

  assign pos_n   = pos + W'(1);
  assign blk_n   = blk + W'(1);
  assign off_n   = off + c_ainc;
  assign bbase_n = bbase + c_binc;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_ainc <= '0; c_len <= '0; c_binc <= '0; c_nblk <= '0;
      bbase  <= '0; off   <= '0; pos    <= '0; blk    <= '0;
      addr   <= '0; valid <= 1'b0; bdone <= 1'b0; done <= 1'b0;
      sout   <= 1'b0;
    end else begin
      sout <= 1'b0;
      if (!valid) begin
        if (start) begin
          c_ainc <= cfg_ainc;
          c_len  <= cfg_len;
          c_binc <= cfg_binc;
          c_nblk <= cfg_nblk;
          bbase  <= cfg_base;
          off    <= '0;
          pos    <= '0;
          blk    <= '0;
          addr   <= cfg_base;
          valid  <= 1'b1;
          sout   <= 1'b1;
          bdone  <= (cfg_len == '0);
          done   <= (cfg_len == '0) && (cfg_nblk == '0);
        end
      end else if (done) begin
        valid <= 1'b0;
        bdone <= 1'b0;
        done  <= 1'b0;
      end else if (pos == c_len) begin
        pos   <= '0;
        off   <= '0;
        blk   <= blk_n;
        bbase <= bbase_n;
        addr  <= bbase_n;
        bdone <= (c_len == '0);
        done  <= (c_len == '0) && (blk_n == c_nblk);
      end else begin
        pos   <= pos_n;
        off   <= off_n;
        addr  <= bbase + off_n;
        bdone <= (pos_n == c_len);
        done  <= (pos_n == c_len) && (blk == c_nblk);
      end
    end
  end

  // R3: block and sequence flags only accompany an address
  a_r3_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
    (bdone || done || sout) |-> valid);
  // R4/R5: the final address also closes its block
  a_r4_done_closes_block: assert property (@(posedge clk) disable iff (rst)
    done |-> bdone);
  // R5: the lane goes idle right after the final address
  a_r5_idle_after_done: assert property (@(posedge clk) disable iff (rst)
    (valid && done) |=> !valid);
  // R7: a running sequence continues regardless of start
  a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
    (valid && !done) |=> (valid && !sout));
  // R6: start echo marks the first address only
  a_r6_echo_on_first: assert property (@(posedge clk) disable iff (rst)
    sout |-> !$past(valid));
  // R2: inside a block, consecutive addresses differ by the step
  a_r2_step_inside_block: assert property (@(posedge clk) disable iff (rst)
    (valid && !bdone) |=> (addr == $past(addr) + $past(c_ainc)));
endmodule

// File: rtl/addr_seq_gen.sv
module addr_seq_gen
  import addr_seq_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_cs,
  input  logic          cpu_wr,
  input  logic          cpu_a0,
  input  logic [DW-1:0] cpu_d,
  input  logic [1:0]    start_in,
  output logic [AW-1:0] addr_out,
  output logic [1:0]    addr_valid,
  output logic [1:0]    blk_done,
  output logic [1:0]    seq_done,
  output logic [1:0]    busy,
  output logic [1:0]    start_out
);
  localparam int HW = AW / 2;
  localparam int UW = AW - HW;

  logic [NREG-1:0][AW-1:0] regs;
  logic [NREG-1:0][AW-1:0] lo_cfg;
  logic [NREG-1:0][UW-1:0] hi_cfg;
  logic [AW-1:0]           lo_mask;
  logic                    split_act, split_eff, both_idle;
  logic [AW-1:0]           a0_addr;
  logic [UW-1:0]           a1_addr;

  addr_seq_cfg #(.DW(DW), .RW(AW)) u_cfg (
    .clk(clk), .rst(rst), .cs(cpu_cs), .wr(cpu_wr), .a0(cpu_a0),
    .d(cpu_d), .regs(regs)
  );

  assign both_idle = !addr_valid[0] && !addr_valid[1];
  assign split_eff = both_idle ? regs[REG_MODE][0] : split_act;
  assign lo_mask   = split_eff ? {{UW{1'b0}}, {HW{1'b1}}} : {AW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)            split_act <= 1'b0;
    else if (both_idle) split_act <= regs[REG_MODE][0];
  end

  for (genvar i = 0; i < NREG; i++) begin : g_cfg
    assign lo_cfg[i] = regs[i] & lo_mask;
    assign hi_cfg[i] = regs[i][AW-1:HW];
  end

  addr_seq_lane #(.W(AW)) u_lane0 (
    .clk(clk), .rst(rst), .start(start_in[0]),
    .cfg_base(lo_cfg[REG_BASE]), .cfg_ainc(lo_cfg[REG_AINC]),
    .cfg_len(lo_cfg[REG_LEN]), .cfg_binc(lo_cfg[REG_BINC]),
    .cfg_nblk(lo_cfg[REG_NBLK]),
    .addr(a0_addr), .valid(addr_valid[0]), .bdone(blk_done[0]),
    .done(seq_done[0]), .sout(start_out[0])
  );

  addr_seq_lane #(.W(UW)) u_lane1 (
    .clk(clk), .rst(rst), .start(start_in[1] && split_eff),
    .cfg_base(hi_cfg[REG_BASE]), .cfg_ainc(hi_cfg[REG_AINC]),
    .cfg_len(hi_cfg[REG_LEN]), .cfg_binc(hi_cfg[REG_BINC]),
    .cfg_nblk(hi_cfg[REG_NBLK]),
    .addr(a1_addr), .valid(addr_valid[1]), .bdone(blk_done[1]),
    .done(seq_done[1]), .sout(start_out[1])
  );

  assign busy     = addr_valid;
  assign addr_out = split_act ? {a1_addr, a0_addr[HW-1:0]} : a0_addr;

  // R11: the upper lane only ever runs in split mode
  a_r11_lane1_needs_split: assert property (@(posedge clk) disable iff (rst)
    addr_valid[1] |-> split_act);
  // R10: the mode cannot change under a running lane
  a_r10_mode_held_while_busy: assert property (@(posedge clk) disable iff (rst)
    (!both_idle && $past(!both_idle)) |-> $stable(split_act));
endmodule

// File: tb/tb_addr_seq_gen.sv
`timescale 1ns/1ps
module tb_addr_seq_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_cs = 1'b0, cpu_wr = 1'b0, cpu_a0 = 1'b0;
  logic [6:0]  cpu_d = '0;
  logic [1:0]  start_in = '0;
  logic [23:0] addr_out;
  logic [1:0]  addr_valid, blk_done, seq_done, busy, start_out;

  always #4 clk = ~clk;

  addr_seq_gen dut (
    .clk(clk), .rst(rst), .cpu_cs(cpu_cs), .cpu_wr(cpu_wr), .cpu_a0(cpu_a0),
    .cpu_d(cpu_d), .start_in(start_in), .addr_out(addr_out),
    .addr_valid(addr_valid), .blk_done(blk_done), .seq_done(seq_done),
    .busy(busy), .start_out(start_out)
  );

  typedef struct {
    int unsigned a;
    bit bd;
    bit dn;
    bit first;
  } exp_t;

  exp_t q0[$];
  exp_t q1[$];
  int   nchk = 0, nfail = 0;
  bit   split_tb = 1'b0;
  bit   mon_on = 1'b0;
  bit   finished = 1'b0;

  task automatic chk(string req, int unsigned got, int unsigned exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic push(int lane, int unsigned base, int unsigned ainc,
                      int unsigned len, int unsigned binc, int unsigned nblk,
                      int unsigned mask);
    for (int unsigned b = 0; b <= nblk; b++) begin
      for (int unsigned k = 0; k <= len; k++) begin
        exp_t e;
        e.a     = (base + b*binc + k*ainc) & mask;
        e.bd    = (k == len);
        e.dn    = (k == len) && (b == nblk);
        e.first = (b == 0) && (k == 0);
        if (lane == 0) q0.push_back(e);
        else           q1.push_back(e);
      end
    end
  endtask

  task automatic mon_lane(int l);
    exp_t e;
    int unsigned got;
    if (addr_valid[l]) begin
      if ((l == 0 && q0.size() == 0) || (l == 1 && q1.size() == 0)) begin
        chk((l == 1 && !split_tb) ? "R11 lane1 stray address" : "R7 unexpected address",
            32'(addr_valid[l]), 0);
      end else begin
        if (l == 0) e = q0.pop_front();
        else        e = q1.pop_front();
        if (l == 1)        got = 32'(addr_out[23:12]);
        else if (split_tb) got = 32'(addr_out[11:0]);
        else               got = 32'(addr_out);
        chk(split_tb ? "R10 lane address" : "R2 address", got, e.a);
        chk("R4 block end", 32'(blk_done[l]), 32'(e.bd));
        chk("R5 sequence end", 32'(seq_done[l]), 32'(e.dn));
        chk("R6 start echo", 32'(start_out[l]), 32'(e.first));
        chk("R3 busy", 32'(busy[l]), 1);
      end
    end else begin
      chk("R3 idle flags", 32'({busy[l], blk_done[l], seq_done[l], start_out[l]}), 0);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && !finished) begin
      mon_lane(0);
      mon_lane(1);
    end
  end

  task automatic bus_wr(bit a0, logic [6:0] d, bit cs = 1'b1, bit wr = 1'b1);
    @(negedge clk);
    cpu_cs = cs; cpu_wr = wr; cpu_a0 = a0; cpu_d = d;
    @(negedge clk);
    cpu_cs = 1'b0; cpu_wr = 1'b0; cpu_a0 = 1'b0; cpu_d = '0;
  endtask

  task automatic wr_reg(int idx, int unsigned val);
    for (int c = 0; c < 4; c++) begin
      bus_wr(1'b0, {2'b00, 2'(c), 3'(idx)});
      bus_wr(1'b1, 7'((val >> (7*c)) & 32'h7f));
    end
  endtask

  task automatic load(int unsigned base, int unsigned ainc, int unsigned len,
                      int unsigned binc, int unsigned nblk);
    wr_reg(0, base); wr_reg(1, ainc); wr_reg(2, len);
    wr_reg(3, binc); wr_reg(4, nblk);
  endtask

  task automatic pulse(int l);
    @(negedge clk);
    start_in[l] = 1'b1;
    @(negedge clk);
    start_in[l] = 1'b0;
  endtask

  task automatic drain();
    while (q0.size() != 0 || q1.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog: got hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset outputs",
        32'({addr_valid, blk_done, seq_done, busy, start_out}), 0);
    chk("R1 reset address", 32'(addr_out), 0);
    mon_on = 1'b1;

    // R2 R4 R5 R6: joined, 4 addresses x 3 blocks
    load(24'h100000, 3, 3, 24'h40, 2);
    push(0, 24'h100000, 3, 3, 24'h40, 2, 24'hffffff);
    pulse(0);
    drain();

    // R2: modulo wrap of the 24-bit address
    load(24'hfffff0, 5, 4, 24'h10, 1);
    push(0, 24'hfffff0, 5, 4, 24'h10, 1, 24'hffffff);
    pulse(0);
    drain();

    // R4: one address per block, every address closes a block
    load(7, 1, 0, 2, 3);
    push(0, 7, 1, 0, 2, 3, 24'hffffff);
    pulse(0);
    drain();

    // R7: restart attempts during a long sequence are ignored
    load(24'h2000, 1, 5, 24'h100, 1);
    push(0, 24'h2000, 1, 5, 24'h100, 1, 24'hffffff);
    pulse(0);
    repeat (2) @(negedge clk);
    pulse(0);
    repeat (2) @(negedge clk);
    pulse(0);
    drain();

    // R8: rewrite the address step while busy
    load(24'h300, 2, 7, 24'h1000, 1);
    push(0, 24'h300, 2, 7, 24'h1000, 1, 24'hffffff);
    pulse(0);
    wr_reg(1, 9);
    drain();
    push(0, 24'h300, 9, 7, 24'h1000, 1, 24'hffffff);
    pulse(0);
    drain();

    // R9: writes lacking a strobe change nothing
    bus_wr(1'b0, 7'b0000000, 1'b0, 1'b1);
    bus_wr(1'b1, 7'h55, 1'b0, 1'b1);
    bus_wr(1'b1, 7'h2a, 1'b1, 1'b0);
    push(0, 24'h300, 9, 7, 24'h1000, 1, 24'hffffff);
    pulse(0);
    drain();

    // R10: split mode, two lanes overlapped
    load({12'h800, 12'h010}, {12'h002, 12'h001}, {12'd1, 12'd2},
         {12'h100, 12'h020}, {12'd2, 12'd1});
    wr_reg(5, 1);
    split_tb = 1'b1;
    push(0, 12'h010, 1, 2, 12'h020, 1, 12'hfff);
    push(1, 12'h800, 2, 1, 12'h100, 2, 12'hfff);
    pulse(0);
    @(negedge clk);
    pulse(1);
    drain();

    // R10: lane 1 alone, with 12-bit wrap
    load({12'hffe, 12'h0}, {12'h001, 12'h0}, {12'd3, 12'd0},
         {12'h000, 12'h0}, {12'd0, 12'd0});
    push(1, 12'hffe, 1, 3, 0, 0, 12'hfff);
    pulse(1);
    drain();

    // R11: joined mode ignores the second start
    wr_reg(5, 0);
    repeat (2) @(negedge clk);
    split_tb = 1'b0;
    pulse(1);
    repeat (4) @(negedge clk);
    chk("R11 no lane activity", 32'(addr_valid), 0);
    load(24'h00abc0, 4, 1, 24'h8, 0);
    push(0, 24'h00abc0, 4, 1, 24'h8, 0, 24'hffffff);
    pulse(0);
    drain();

    finish_run();
  end
endmodule